// File: doc/BRIEF.md
# Multiplexed External Memory Bus Interface

This block turns single-byte requests from a processor core into cycles on a narrow external memory bus. The bus has two spaces. Code space is read-only, and data space can be read and written. Each space is up to 64K bytes.

Eight address bits reach the pins on a dedicated high-byte port. The low address byte and the data share one 8-bit port, so the block puts the low address out first and pulses an active-high latch enable while it is valid. An external transparent latch captures the byte on that pulse, and the port is then turned around for data. Code reads use their own active-low strobe. Data reads and data writes each have a separate active-low strobe. An active-low external-access input selects where the lowest code addresses go: they are either served by on-chip ROM or sent out on the bus.

The core holds a request (valid, kind, 16-bit address, write byte) until it sees a one-clock ready pulse. The clock is the oscillator clock. An external access takes exactly one machine cycle of twelve oscillator clocks, counted from the edge that accepts the request up to the return to idle. Each phase length is a parameter.

The state machine has seven states: IDLE, ALE, HOLD, TURN, STRB, REL and DONE. Its transitions are:
- IDLE to ALE when a request is present and must go to the bus.
- IDLE to DONE when the request is a code fetch served on-chip.
- ALE to HOLD, HOLD to TURN, TURN to STRB and STRB to REL, each when the phase timer expires.
- REL to DONE when its timer expires.
- DONE to IDLE unconditionally.

Top module: `ext_bus_ctrl`

## Requirements
- R1: While reset is held, and while idle, the latch enable is low, all three strobes are high, the shared port is not driven and ready is low.
- R2: An external access begins with the latch enable high for 2 clocks. During that time the shared port drives the low address byte, and the low address stays driven for 1 more clock after the latch enable falls. The high-byte port shows the high address byte for the whole access.
- R3: A code fetch (kind 2'b00) holds the program-store strobe low for 6 clocks, starting 4 clocks after acceptance. The shared port is released from the turnaround clock onward, and the data read and write strobes stay high.
- R4: A data read (kind 2'b01, and also kind 2'b11) holds the read strobe low over the same 6 clocks and releases the shared port. The program-store strobe stays high.
- R5: For reads, the response byte is the shared-port input sampled on the clock edge at which the strobe rises. It is valid with ready and holds until the next bus read. An on-chip fetch leaves it unchanged.
- R6: A data write (kind 2'b10) holds the write strobe low over the same 6 clocks. The write byte is driven on the shared port from the turnaround clock until one clock after the write strobe rises.
- R7: Ready pulses for exactly one clock, in the 12th clock after acceptance. A new request is accepted one clock after the ready pulse at the earliest.
- R8: A code fetch below 16'h1000 with the external-access input high causes no bus activity: ready pulses in the clock after acceptance with the internal flag high. Any other access goes to the bus and returns the internal flag low. Data accesses ignore the external-access input.
- R9: At most one of the latch enable, program-store strobe, read strobe and write strobe is active at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Core request present, held until ready |
| req_kind | input | 2 | 00 code fetch, 01 data read, 10 data write, 11 data read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Byte to write |
| ext_access_n | input | 1 | Low: low code range goes to the bus |
| req_ready | output | 1 | One-clock completion pulse |
| rsp_internal | output | 1 | With ready: fetch was served on-chip |
| rsp_rdata | output | 8 | Byte from the last bus read |
| latch_en | output | 1 | Active-high low-address latch strobe |
| prog_rd_n | output | 1 | Active-low code read strobe |
| data_rd_n | output | 1 | Active-low data read strobe |
| data_wr_n | output | 1 | Active-low data write strobe |
| addr_hi | output | 8 | High address byte port |
| ad_out | output | 8 | Shared port output value |
| ad_oe | output | 1 | Shared port output enable |
| ad_in | input | 8 | Shared port input value |

## Verification
The assertions assume that the core keeps each request valid and stable until ready, and that it raises no request while a bus cycle or the ready clock is in progress. The bench therefore presents each request on a falling edge and drops it on the falling edge at which ready is seen. It then waits one idle clock before the next request. The external memories are modelled in the bench. A latch captures the low address when the latch enable falls, read data is computed from the latched address while a read strobe is low, and a write capture samples the port when the write strobe rises.

// File: rtl/ebi_pkg.sv
package ebi_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_ALE, ST_HOLD, ST_TURN, ST_STRB, ST_REL, ST_DONE
    } bus_state_e;

    typedef enum logic [1:0] {
        K_CODE   = 2'b00,
        K_RD     = 2'b01,
        K_WR     = 2'b10,
        K_RD_ALT = 2'b11
    } acc_kind_e;
endpackage

// File: rtl/ebi_phase_timer.sv
module ebi_phase_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
    import ebi_pkg::*;
#(
    parameter int          ALE_CLKS  = 2,
    parameter int          HOLD_CLKS = 1,
    parameter int          TURN_CLKS = 1,
    parameter int          STRB_CLKS = 6,
    parameter int          REL_CLKS  = 1,
    parameter logic [15:0] ROM_TOP   = 16'h1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [1:0]  req_kind,
    input  logic [15:0] req_addr,
    input  logic [7:0]  req_wdata,
    input  logic        ext_access_n,
    output logic        req_ready,
    output logic        rsp_internal,
    output logic [7:0]  rsp_rdata,
    output logic        latch_en,
    output logic        prog_rd_n,
    output logic        data_rd_n,
    output logic        data_wr_n,
    output logic [7:0]  addr_hi,
    output logic [7:0]  ad_out,
    output logic        ad_oe,
    input  logic [7:0]  ad_in
);
    localparam int MAX_A = (ALE_CLKS > HOLD_CLKS) ? ALE_CLKS : HOLD_CLKS;
    localparam int MAX_B = (TURN_CLKS > STRB_CLKS) ? TURN_CLKS : STRB_CLKS;
    localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_L = (MAX_C > REL_CLKS) ? MAX_C : REL_CLKS;
    localparam int CNT_W = (MAX_L > 1) ? $clog2(MAX_L) : 1;

    bus_state_e  state_q, state_d;
    acc_kind_e   kind_q;
    logic [15:0] addr_q;
    logic [7:0]  wdata_q;
    logic [7:0]  rdata_q;
    logic        int_q;
    logic        phase_last;
    logic        go_internal;
    logic [CNT_W-1:0] load_val;

    assign go_internal = (acc_kind_e'(req_kind) == K_CODE) && ext_access_n
                         && (req_addr < ROM_TOP);

    function automatic logic [CNT_W-1:0] phase_len(input bus_state_e s);
        case (s)
            ST_ALE:  return CNT_W'(ALE_CLKS - 1);
            ST_HOLD: return CNT_W'(HOLD_CLKS - 1);
            ST_TURN: return CNT_W'(TURN_CLKS - 1);
            ST_STRB: return CNT_W'(STRB_CLKS - 1);
            ST_REL:  return CNT_W'(REL_CLKS - 1);
            default: return '0;
        endcase
    endfunction

    assign load_val = phase_len(state_d);

    ebi_phase_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state_d != state_q),
        .load_val (load_val),
        .last     (phase_last)
    );

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = go_internal ? ST_DONE : ST_ALE;
            ST_ALE:  if (phase_last) state_d = ST_HOLD;
            ST_HOLD: if (phase_last) state_d = ST_TURN;
            ST_TURN: if (phase_last) state_d = ST_STRB;
            ST_STRB: if (phase_last) state_d = ST_REL;
            ST_REL:  if (phase_last) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= K_CODE;
            addr_q  <= '0;
            wdata_q <= '0;
            int_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) begin
                kind_q  <= acc_kind_e'(req_kind);
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                int_q   <= go_internal;
            end
            if (state_q == ST_STRB && phase_last && kind_q != K_WR)
                rdata_q <= ad_in;
        end
    end

    // bus outputs per state
    always_comb begin
        latch_en  = 1'b0;
        prog_rd_n = 1'b1;
        data_rd_n = 1'b1;
        data_wr_n = 1'b1;
        ad_oe     = 1'b0;
        ad_out    = addr_q[7:0];
        req_ready = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ALE: begin
                latch_en = 1'b1;
                ad_oe    = 1'b1;
            end
            ST_HOLD: ad_oe = 1'b1;
            ST_TURN: if (kind_q == K_WR) begin
                ad_oe  = 1'b1;
                ad_out = wdata_q;
            end
            ST_STRB: begin
                if (kind_q == K_CODE) prog_rd_n = 1'b0;
                else if (kind_q == K_WR) begin
                    data_wr_n = 1'b0;
                    ad_oe     = 1'b1;
                    ad_out    = wdata_q;
                end else data_rd_n = 1'b0;
            end
            ST_REL: if (kind_q == K_WR) begin
                ad_oe  = 1'b1;
                ad_out = wdata_q;
            end
            ST_DONE: req_ready = 1'b1;
            default: ;
        endcase
    end

    assign addr_hi      = addr_q[15:8];
    assign rsp_internal = int_q;
    assign rsp_rdata    = rdata_q;

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({latch_en, !prog_rd_n, !data_rd_n, !data_wr_n}));

    // R6
    wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !data_wr_n |-> ad_oe);

    // R6
    wr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_wr_n) |-> ad_oe);

    // R3 R4
    rd_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!prog_rd_n || !data_rd_n) |-> !ad_oe);

    // R2
    adr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(latch_en) |-> (ad_oe && $stable(ad_out)));

    // R2
    hi_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!prog_rd_n || !data_rd_n || !data_wr_n) |-> $stable(addr_hi));

    // R7
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);
endmodule

// File: tb/sim_ext_bus_ctrl.sv
module sim_ext_bus_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ext_access_n = 1'b1;
    logic        req_ready, rsp_internal, latch_en;
    logic        prog_rd_n, data_rd_n, data_wr_n, ad_oe;
    logic [7:0]  rsp_rdata, addr_hi, ad_out, ad_in;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    ext_bus_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .ext_access_n(ext_access_n),
        .req_ready(req_ready), .rsp_internal(rsp_internal), .rsp_rdata(rsp_rdata),
        .latch_en(latch_en), .prog_rd_n(prog_rd_n), .data_rd_n(data_rd_n),
        .data_wr_n(data_wr_n), .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe),
        .ad_in(ad_in)
    );

    // external memory models
    function automatic logic [7:0] code_byte(input logic [15:0] a);
        return (a[7:0] + 8'(3 * a[15:8])) ^ 8'h3C;
    endfunction
    function automatic logic [7:0] data_byte(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h96;
    endfunction

    logic [7:0]  lat_lo = '0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_byte = '0;
    int          wr_cnt = 0;

    always @(negedge latch_en) lat_lo = ad_out;
    always @(posedge data_wr_n) begin
        wr_addr = {addr_hi, lat_lo};
        wr_byte = ad_out;
        wr_cnt++;
    end
    always_comb begin
        if (!prog_rd_n)      ad_in = code_byte({addr_hi, lat_lo});
        else if (!data_rd_n) ad_in = data_byte({addr_hi, lat_lo});
        else                 ad_in = 8'hFF;
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk({tag, " latch_en"}, 16'(latch_en), 16'd0);
        chk({tag, " strobes"}, 16'({prog_rd_n, data_rd_n, data_wr_n}), 16'h7);
        chk({tag, " ad_oe"}, 16'(ad_oe), 16'd0);
        chk({tag, " ready"}, 16'(req_ready), 16'd0);
    endtask

    logic [7:0] prev_rd = '0;

    // reference model: expected pins per clock of one access
    task automatic access(input logic [1:0] kind, input logic [15:0] a,
                          input logic [7:0] wd, input logic ea_n);
        bit internal = (kind == 2'b00) && ea_n && (a < 16'h1000);
        bit is_wr = (kind == 2'b10);
        bit is_code = (kind == 2'b00);
        bit is_rd = !is_wr && !is_code;
        int n = internal ? 1 : 12;
        logic [7:0] exp_rd = is_code ? code_byte(a) : data_byte(a);
        int wr_before = wr_cnt;
        ext_access_n = ea_n;
        req_kind = kind;
        req_addr = a;
        req_wdata = wd;
        req_valid = 1'b1;
        for (int t = 0; t < n; t++) begin
            @(negedge clk);
            if (internal) begin
                // R8 on-chip fetch: no bus cycle, immediate ready
                chk("R8 int ready", 16'(req_ready), 16'd1);
                chk("R8 int flag", 16'(rsp_internal), 16'd1);
                chk("R8 no strobe", 16'({latch_en, prog_rd_n, data_rd_n, data_wr_n, ad_oe}), 16'b01110);
                chk("R5 rdata kept", 16'(rsp_rdata), 16'(prev_rd));
            end else begin
                bit strb = (t >= 4) && (t <= 9);
                bit oe = (t < 3) || (is_wr && t <= 10);
                chk("R2 latch_en", 16'(latch_en), 16'(t < 2));
                chk("R2 addr_hi", 16'(addr_hi), 16'(a[15:8]));
                chk("R3 prog_rd_n", 16'(prog_rd_n), 16'(!(is_code && strb)));
                chk("R4 data_rd_n", 16'(data_rd_n), 16'(!(is_rd && strb)));
                chk("R6 data_wr_n", 16'(data_wr_n), 16'(!(is_wr && strb)));
                chk("R6 ad_oe", 16'(ad_oe), 16'(oe));
                if (oe) chk("R2 R6 ad_out", 16'(ad_out), t < 3 ? 16'(a[7:0]) : 16'(wd));
                chk("R7 ready", 16'(req_ready), 16'(t == 11));
                if (t == 11) begin
                    chk("R8 ext flag", 16'(rsp_internal), 16'd0);
                    if (!is_wr) begin
                        chk("R5 rdata", 16'(rsp_rdata), 16'(exp_rd));
                        prev_rd = exp_rd;
                    end else
                        chk("R5 rdata after write", 16'(rsp_rdata), 16'(prev_rd));
                end
            end
        end
        req_valid = 1'b0;
        @(negedge clk);
        chk_idle("R7 R1 after");
        if (is_wr) begin
            chk("R6 write count", 16'(wr_cnt - wr_before), 16'd1);
            chk("R6 write addr", wr_addr, a);
            chk("R6 write byte", 16'(wr_byte), 16'(wd));
        end else
            chk("R6 no write", 16'(wr_cnt - wr_before), 16'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_idle("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1 idle");
        access(2'b00, 16'h0123, 8'h00, 1'b0);   // R3 R8 low code to bus
        access(2'b00, 16'h0FFF, 8'h00, 1'b1);   // R8 on-chip
        access(2'b00, 16'h1000, 8'h00, 1'b1);   // R8 boundary external
        access(2'b01, 16'h0040, 8'h00, 1'b1);   // R4 R8 data ignores ext_access_n
        access(2'b10, 16'hBEEF, 8'hA5, 1'b1);   // R6
        access(2'b00, 16'h0002, 8'h00, 1'b1);   // R5 unchanged on on-chip
        access(2'b11, 16'h8001, 8'h00, 1'b0);   // R4 alt read kind
        access(2'b10, 16'h0000, 8'h5A, 1'b0);   // R6
        access(2'b10, 16'hFFFF, 8'hFF, 1'b0);   // R6 back to back
        access(2'b00, 16'hFFFE, 8'h00, 1'b0);   // R3
        // R1 idle with no request
        repeat (3) @(negedge clk);
        chk_idle("R1 quiet");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule